// File: doc/BRIEF.md
# Privileged Time-Stamp Counter Unit

This block keeps a 64-bit count that advances by one on each cycle where the constant-rate `tick` input is high. The count does not depend on any power, sleep or throttle state. Next to the count sits a 32-bit signature register. Privileged software loads the signature with a value that identifies the logical processor. Three kinds of request are served:

- A plain count read.
- A paired read, which returns both count halves and the signature as one atomic snapshot.
- Register-style reads and writes through an address port.

Every read is checked against a disable flag and the requester's privilege level. A refused request returns a fault and no data.

Requests are sampled on a clock edge. The response appears on the following cycle as a one-cycle `rsp_valid` strobe with fault and error bits. If several requests are raised together, only the highest-priority one is served. The parameter `FULL_WR` selects how a register write reaches the count: either all 64 bits are loaded, or only the low half is loaded and the high half is cleared.

Top module: `tsc_unit`

## Requirements
- R1: After reset the count and the signature are zero and `rsp_valid`, `rsp_fault` and `rsp_err` are low.
- R2: The count rises by exactly one on each cycle with `tick` high and holds on cycles without it. The all-ones value rolls over to zero.
- R3: A plain read (`rd_ctr_req`) returns the count as it stood in the request cycle, on `rsp_hi` (bits 63..32) and `rsp_lo` (bits 31..0). The response comes one cycle later with `rsp_valid` high for that single cycle, and `rsp_sig` is zero.
- R4: A paired read (`rd_pair_req`) returns the count halves and the signature on `rsp_sig`, all taken from the same request cycle.
- R5: When `tsd_flag` is 1, a plain or paired read with `cpl` other than 0 returns `rsp_fault`=1 and all data outputs zero. When `tsd_flag` is 0, both reads are allowed at every `cpl` value 0..3.
- R6: A register read or write with `cpl` other than 0 faults, and the write leaves the count and the signature unchanged.
- R7: A register read at address 0x010 returns all 64 count bits. Address 0x011 holds the signature, which is written from `reg_wdata[31:0]` and read back on `rsp_lo`.
- R8: With `FULL_WR`=1, a register write to 0x010 loads all 64 bits. With `FULL_WR`=0 it loads `reg_wdata[31:0]` into the low half and clears the high half.
- R9: When a count write and a tick fall in the same cycle, the written value is stored. Counting resumes from it on the next tick.
- R10: A privileged register access to any address other than 0x010 or 0x011 returns `rsp_err`=1 with zero data and changes no state.
- R11: When requests coincide, priority runs from highest to lowest as register write, register read, paired read, plain read. Only the winner is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Constant-rate count enable |
| tsd_flag | input | 1 | Restricts plain and paired reads to privilege 0 |
| cpl | input | 2 | Current privilege level of the requester |
| rd_ctr_req | input | 1 | Plain count read |
| rd_pair_req | input | 1 | Paired count plus signature read |
| reg_rd_req | input | 1 | Register read at `reg_addr` |
| reg_wr_req | input | 1 | Register write at `reg_addr` |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 64 | Register write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Request refused for privilege |
| rsp_err | output | 1 | Unimplemented register address |
| rsp_hi | output | 32 | Count bits 63..32 |
| rsp_lo | output | 32 | Count bits 31..0, or the signature on a register read of 0x011 |
| rsp_sig | output | 32 | Signature on a paired read |

## Verification
A count write and a tick can land on the same edge. A read snapshot and a tick can also coincide. In that case the returned value must be the pre-increment count while the stored count moves on. The bench provokes both overlaps by raising `tick` together with writes and reads, including a write of all-ones-minus-one that is then ticked through the rollover. It judges each response against an arithmetic model of both write-mode variants, driven with identical stimulus, and reads back the count through the address port to confirm which update won.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TSC_CW = 64;
  localparam int TSC_HW = TSC_CW / 2;
  localparam int TSC_SW = 32;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CTR,
    OP_PAIR,
    OP_RRD,
    OP_RWR
  } tsc_op_e;

  typedef struct packed {
    logic              valid;
    logic              fault;
    logic              err;
    logic [TSC_HW-1:0] hi;
    logic [TSC_HW-1:0] lo;
    logic [TSC_SW-1:0] sig;
  } tsc_rsp_t;
endpackage

// File: rtl/tsc_gate.sv
module tsc_gate
  import tsc_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CTR_ADDR = 'h010,
  parameter int AUX_ADDR = 'h011
) (
  input  logic          rd_ctr_req,
  input  logic          rd_pair_req,
  input  logic          reg_rd_req,
  input  logic          reg_wr_req,
  input  logic          tsd_flag,
  input  logic [1:0]    cpl,
  input  logic [AW-1:0] reg_addr,
  output tsc_op_e       op,
  output logic          fault,
  output logic          err,
  output logic          sel_ctr,
  output logic          sel_aux,
  output logic          ctr_we,
  output logic          aux_we
);
  logic priv;
  logic user_ok;
  logic hit_ctr;
  logic hit_aux;

  always_comb begin
    priv    = (cpl == 2'd0);
    user_ok = !tsd_flag || priv;
    hit_ctr = (reg_addr == AW'(CTR_ADDR));
    hit_aux = (reg_addr == AW'(AUX_ADDR));
  end

  always_comb begin
    op      = OP_NONE;
    fault   = 1'b0;
    err     = 1'b0;
    sel_ctr = 1'b0;
    sel_aux = 1'b0;
    ctr_we  = 1'b0;
    aux_we  = 1'b0;
    if (reg_wr_req) begin
      op     = OP_RWR;
      fault  = !priv;
      err    = priv && !hit_ctr && !hit_aux;
      ctr_we = priv && hit_ctr;
      aux_we = priv && hit_aux;
    end else if (reg_rd_req) begin
      op      = OP_RRD;
      fault   = !priv;
      err     = priv && !hit_ctr && !hit_aux;
      sel_ctr = priv && hit_ctr;
      sel_aux = priv && hit_aux;
    end else if (rd_pair_req) begin
      op    = OP_PAIR;
      fault = !user_ok;
    end else if (rd_ctr_req) begin
      op    = OP_CTR;
      fault = !user_ok;
    end
  end
endmodule

// File: rtl/tsc_store.sv
module tsc_store
  import tsc_pkg::*;
#(
  parameter bit FULL_WR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctr_we,
  input  logic              aux_we,
  input  logic [TSC_CW-1:0] wdata,
  output logic [TSC_CW-1:0] count_q,
  output logic [TSC_SW-1:0] aux_q
);
  localparam logic [TSC_CW-1:0] ONE = {{(TSC_CW-1){1'b0}}, 1'b1};

  logic [TSC_CW-1:0] wr_val;
  logic [TSC_CW-1:0] count_d;
  logic              count_en;
  logic [TSC_SW-1:0] aux_d;
  logic              aux_en;

  generate
    if (FULL_WR) begin : g_full
      assign wr_val = wdata;
    end else begin : g_legacy
      assign wr_val = {{TSC_HW{1'b0}}, wdata[TSC_HW-1:0]};
    end
  endgenerate

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (ctr_we) begin
      count_en = 1'b1;
      count_d  = wr_val;
    end else if (tick) begin
      count_en = 1'b1;
      count_d  = count_q + ONE;
    end
    aux_en = aux_we;
    aux_d  = wdata[TSC_SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (aux_en) begin
      aux_q <= aux_d;
    end
  end
endmodule

// File: rtl/tsc_resp.sv
module tsc_resp
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tsc_op_e           op,
  input  logic              fault,
  input  logic              err,
  input  logic              sel_ctr,
  input  logic              sel_aux,
  input  logic [TSC_CW-1:0] count_q,
  input  logic [TSC_SW-1:0] aux_q,
  output tsc_rsp_t          rsp_q
);
  tsc_rsp_t rsp_d;
  logic     rsp_en;

  always_comb begin
    rsp_d       = '0;
    rsp_d.valid = (op != OP_NONE);
    rsp_d.fault = fault;
    rsp_d.err   = err;
    if (!fault && !err) begin
      case (op)
        OP_CTR: begin
          rsp_d.hi = count_q[TSC_CW-1:TSC_HW];
          rsp_d.lo = count_q[TSC_HW-1:0];
        end
        OP_PAIR: begin
          rsp_d.hi  = count_q[TSC_CW-1:TSC_HW];
          rsp_d.lo  = count_q[TSC_HW-1:0];
          rsp_d.sig = aux_q;
        end
        OP_RRD: begin
          if (sel_ctr) begin
            rsp_d.hi = count_q[TSC_CW-1:TSC_HW];
            rsp_d.lo = count_q[TSC_HW-1:0];
          end else if (sel_aux) begin
            rsp_d.lo = TSC_HW'(aux_q);
          end
        end
        default: ;
      endcase
    end
    rsp_en = rsp_d.valid || rsp_q.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else if (rsp_en) begin
      rsp_q <= rsp_d;
    end
  end
endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
  import tsc_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CTR_ADDR = 'h010,
  parameter int AUX_ADDR = 'h011,
  parameter bit FULL_WR  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tsd_flag,
  input  logic [1:0]        cpl,
  input  logic              rd_ctr_req,
  input  logic              rd_pair_req,
  input  logic              reg_rd_req,
  input  logic              reg_wr_req,
  input  logic [AW-1:0]     reg_addr,
  input  logic [TSC_CW-1:0] reg_wdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_err,
  output logic [TSC_HW-1:0] rsp_hi,
  output logic [TSC_HW-1:0] rsp_lo,
  output logic [TSC_SW-1:0] rsp_sig
);
  logic              rst_meta;
  logic              rst_ok;
  tsc_op_e           op;
  logic              fault;
  logic              err;
  logic              sel_ctr;
  logic              sel_aux;
  logic              ctr_we;
  logic              aux_we;
  logic [TSC_CW-1:0] count_q;
  logic [TSC_SW-1:0] aux_q;
  tsc_rsp_t          rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  tsc_gate #(
    .AW(AW), .CTR_ADDR(CTR_ADDR), .AUX_ADDR(AUX_ADDR)
  ) gate_i (
    .rd_ctr_req (rd_ctr_req),
    .rd_pair_req(rd_pair_req),
    .reg_rd_req (reg_rd_req),
    .reg_wr_req (reg_wr_req),
    .tsd_flag   (tsd_flag),
    .cpl        (cpl),
    .reg_addr   (reg_addr),
    .op         (op),
    .fault      (fault),
    .err        (err),
    .sel_ctr    (sel_ctr),
    .sel_aux    (sel_aux),
    .ctr_we     (ctr_we),
    .aux_we     (aux_we)
  );

  tsc_store #(.FULL_WR(FULL_WR)) store_i (
    .clk    (clk),
    .rst_n  (rst_ok),
    .tick   (tick),
    .ctr_we (ctr_we),
    .aux_we (aux_we),
    .wdata  (reg_wdata),
    .count_q(count_q),
    .aux_q  (aux_q)
  );

  tsc_resp resp_i (
    .clk    (clk),
    .rst_n  (rst_ok),
    .op     (op),
    .fault  (fault),
    .err    (err),
    .sel_ctr(sel_ctr),
    .sel_aux(sel_aux),
    .count_q(count_q),
    .aux_q  (aux_q),
    .rsp_q  (rsp_q)
  );

  always_comb begin
    rsp_valid = rsp_q.valid;
    rsp_fault = rsp_q.fault;
    rsp_err   = rsp_q.err;
    rsp_hi    = rsp_q.hi;
    rsp_lo    = rsp_q.lo;
    rsp_sig   = rsp_q.sig;
  end
endmodule

// File: rtl/tsc_unit_chk.sv
module tsc_unit_chk
  import tsc_pkg::*;
#(
  parameter bit FULL_WR = 1'b1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              tick,
  input logic              ctr_we,
  input logic [TSC_CW-1:0] count_q,
  input logic              rd_ctr_req,
  input logic              rd_pair_req,
  input logic              reg_rd_req,
  input logic              reg_wr_req,
  input logic              tsd_flag,
  input logic [1:0]        cpl,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic              rsp_err,
  input logic [TSC_HW-1:0] rsp_hi,
  input logic [TSC_HW-1:0] rsp_lo,
  input logic [TSC_SW-1:0] rsp_sig
);
  logic any_req;
  assign any_req = rd_ctr_req || rd_pair_req || reg_rd_req || reg_wr_req;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !ctr_we) |=> (count_q == $past(count_q) + 64'd1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!tick && !ctr_we) |=> $stable(count_q));

  // R3
  rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    any_req |=> rsp_valid);

  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !any_req |=> !rsp_valid);

  // R5
  tsd_fault_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_ctr_req && !rd_pair_req && !reg_rd_req && !reg_wr_req && tsd_flag && cpl != 2'd0)
      |=> (rsp_valid && rsp_fault));

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_fault |-> (rsp_hi == '0 && rsp_lo == '0 && rsp_sig == '0));

  // R8
  legacy_high_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctr_we && !FULL_WR) |=> (count_q[TSC_CW-1:TSC_HW] == '0));

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_err |-> (!rsp_fault && rsp_hi == '0 && rsp_lo == '0));
endmodule

bind tsc_unit tsc_unit_chk #(.FULL_WR(FULL_WR)) chk_i (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .tick       (tick),
  .ctr_we     (ctr_we),
  .count_q    (count_q),
  .rd_ctr_req (rd_ctr_req),
  .rd_pair_req(rd_pair_req),
  .reg_rd_req (reg_rd_req),
  .reg_wr_req (reg_wr_req),
  .tsd_flag   (tsd_flag),
  .cpl        (cpl),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_err    (rsp_err),
  .rsp_hi     (rsp_hi),
  .rsp_lo     (rsp_lo),
  .rsp_sig    (rsp_sig)
);

// File: tb/tsc_unit_tb_top.sv
`timescale 1ns/1ps
module tsc_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        tsd_flag;
  logic [1:0]  cpl;
  logic        rd_ctr_req, rd_pair_req, reg_rd_req, reg_wr_req;
  logic [11:0] reg_addr;
  logic [63:0] reg_wdata;

  logic        o_valid [2];
  logic        o_fault [2];
  logic        o_err   [2];
  logic [31:0] o_hi    [2];
  logic [31:0] o_lo    [2];
  logic [31:0] o_sig   [2];

  logic [63:0] m_cnt [2];
  logic [31:0] m_aux;
  int n_chk;
  int n_fail;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  tsc_unit #(.FULL_WR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tsd_flag(tsd_flag), .cpl(cpl),
    .rd_ctr_req(rd_ctr_req), .rd_pair_req(rd_pair_req), .reg_rd_req(reg_rd_req),
    .reg_wr_req(reg_wr_req), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(o_valid[0]), .rsp_fault(o_fault[0]), .rsp_err(o_err[0]),
    .rsp_hi(o_hi[0]), .rsp_lo(o_lo[0]), .rsp_sig(o_sig[0]));

  tsc_unit #(.FULL_WR(1'b0)) dut_leg_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tsd_flag(tsd_flag), .cpl(cpl),
    .rd_ctr_req(rd_ctr_req), .rd_pair_req(rd_pair_req), .reg_rd_req(reg_rd_req),
    .reg_wr_req(reg_wr_req), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(o_valid[1]), .rsp_fault(o_fault[1]), .rsp_err(o_err[1]),
    .rsp_hi(o_hi[1]), .rsp_lo(o_lo[1]), .rsp_sig(o_sig[1]));

  task automatic compare(int k, logic ev, logic ef, logic ee,
                         logic [31:0] eh, logic [31:0] el, logic [31:0] es, string req);
    n_chk++;
    if (o_valid[k] !== ev || o_fault[k] !== ef || o_err[k] !== ee ||
        o_hi[k] !== eh || o_lo[k] !== el || o_sig[k] !== es) begin
      n_fail++;
      $display("FAIL %s inst%0d actual v%b f%b e%b %h_%h sig %h expected v%b f%b e%b %h_%h sig %h",
               req, k, o_valid[k], o_fault[k], o_err[k], o_hi[k], o_lo[k], o_sig[k],
               ev, ef, ee, eh, el, es);
    end
  endtask

  task automatic idle();
    tick = 0; rd_ctr_req = 0; rd_pair_req = 0; reg_rd_req = 0; reg_wr_req = 0;
    reg_addr = '0; reg_wdata = '0;
  endtask

  // Called at a negedge: drive, let one edge pass, check at the next negedge.
  task automatic step(bit t, bit rc, bit rp, bit rr, bit rw, logic [11:0] a,
                      logic [63:0] wd, bit sd, logic [1:0] pl, string req);
    logic        ev, ef, ee, priv, uok, hit;
    logic [31:0] eh [2];
    logic [31:0] el [2];
    logic [31:0] es;
    tick = t; rd_ctr_req = rc; rd_pair_req = rp; reg_rd_req = rr; reg_wr_req = rw;
    reg_addr = a; reg_wdata = wd; tsd_flag = sd; cpl = pl;
    @(posedge clk);
    priv = (pl == 2'd0);
    uok  = !sd || priv;
    hit  = (a == 12'h010) || (a == 12'h011);
    ev = rc || rp || rr || rw;
    ef = 0; ee = 0; es = '0;
    for (int k = 0; k < 2; k++) begin eh[k] = '0; el[k] = '0; end
    if (rw) begin
      ef = !priv; ee = priv && !hit;
    end else if (rr) begin
      ef = !priv; ee = priv && !hit;
      if (priv && a == 12'h010)
        for (int k = 0; k < 2; k++) begin eh[k] = m_cnt[k][63:32]; el[k] = m_cnt[k][31:0]; end
      else if (priv && a == 12'h011)
        for (int k = 0; k < 2; k++) el[k] = m_aux;
    end else if (rp || rc) begin
      ef = !uok;
      if (uok) begin
        for (int k = 0; k < 2; k++) begin eh[k] = m_cnt[k][63:32]; el[k] = m_cnt[k][31:0]; end
        if (rp) es = m_aux;
      end
    end
    if (rw && priv && a == 12'h010) begin
      m_cnt[0] = wd;
      m_cnt[1] = {32'h0, wd[31:0]};
    end else if (t) begin
      for (int k = 0; k < 2; k++) m_cnt[k] = m_cnt[k] + 64'd1;
    end
    if (rw && priv && a == 12'h011) m_aux = wd[31:0];
    @(negedge clk);
    for (int k = 0; k < 2; k++) compare(k, ev, ef, ee, eh[k], el[k], es, req);
    idle();
  endtask

  task automatic rd_cnt(string req);
    step(0, 0, 0, 1, 0, 12'h010, '0, 0, 2'd0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_cnt[0] = '0; m_cnt[1] = '0; m_aux = '0;
    rst_n = 0; tsd_flag = 0; cpl = 0;
    idle();
    repeat (4) @(negedge clk);
    // R1: outputs quiet while in reset
    for (int k = 0; k < 2; k++) compare(k, 0, 0, 0, '0, '0, '0, "R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 2; k++) compare(k, 0, 0, 0, '0, '0, '0, "R1");
    step(0, 0, 1, 0, 0, 12'h0, '0, 0, 2'd0, "R1");

    // R2: ticking with no requests, then readback
    for (int i = 0; i < 20; i++) step((i % 3) != 1, 0, 0, 0, 0, 12'h0, '0, 0, 2'd0, "R2");
    rd_cnt("R2");

    // R7: signature write and readback
    step(0, 0, 0, 0, 1, 12'h011, 64'hFFFF_0000_C0DE_0001, 0, 2'd0, "R7");
    step(0, 0, 0, 1, 0, 12'h011, '0, 0, 2'd0, "R7");

    // R3 R4 R5: sweep disable flag, privilege and read kind, tick alternating
    for (int sd = 0; sd < 2; sd++)
      for (int pl = 0; pl < 4; pl++)
        for (int kind = 0; kind < 2; kind++)
          step(kind == 0, kind == 0, kind == 1, 0, 0, 12'h0, '0, sd[0], pl[1:0],
               (sd == 1 && pl != 0) ? "R5" : (kind == 1 ? "R4" : "R3"));

    // R8: write mode variants
    step(0, 0, 0, 0, 1, 12'h010, 64'h1234_5678_9ABC_DEF0, 0, 2'd0, "R8");
    rd_cnt("R8");
    step(1, 0, 1, 0, 0, 12'h0, '0, 1, 2'd0, "R8");

    // R6: unprivileged register access refused, state unchanged
    for (int pl = 1; pl < 4; pl++) begin
      step(0, 0, 0, 0, 1, 12'h010, 64'hDEAD_0000_0000_0000 + 64'(pl), 0, pl[1:0], "R6");
      step(0, 0, 0, 0, 1, 12'h011, 64'(pl * 7), 0, pl[1:0], "R6");
      step(0, 0, 0, 1, 0, 12'h011, '0, 0, pl[1:0], "R6");
    end
    rd_cnt("R6");
    step(0, 0, 0, 1, 0, 12'h011, '0, 0, 2'd0, "R6");

    // R10: unimplemented addresses
    for (int a = 0; a < 32; a++)
      if (a != 16 && a != 17) begin
        step(a[0], 0, 0, a[1], !a[1], 12'(a * 37), 64'hAAAA_5555_AAAA_5555, 0, 2'd0, "R10");
      end
    rd_cnt("R10");
    step(0, 0, 0, 1, 0, 12'h011, '0, 0, 2'd0, "R10");

    // R9: write and tick in the same cycle, then tick through rollover (R2)
    step(1, 0, 0, 0, 1, 12'h010, 64'hFFFF_FFFF_FFFF_FFFE, 0, 2'd0, "R9");
    rd_cnt("R9");
    step(1, 1, 0, 0, 0, 12'h0, '0, 0, 2'd3, "R9");
    step(1, 1, 0, 0, 0, 12'h0, '0, 0, 2'd1, "R2");
    step(0, 0, 1, 0, 0, 12'h0, '0, 0, 2'd0, "R2");

    // R11: coinciding requests
    step(0, 1, 1, 1, 1, 12'h011, 64'h0000_0000_5151_AAAA, 0, 2'd0, "R11");
    step(1, 1, 1, 0, 0, 12'h0, '0, 0, 2'd0, "R11");
    step(0, 0, 1, 1, 0, 12'h010, '0, 0, 2'd0, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = (i % 4 == 0) ? 12'h010 : ((i % 4 == 1) ? 12'h011 : 12'(i));
      step(i[0] ^ i[3], (i % 3) == 0, (i % 5) == 0, (i % 7) == 0, (i % 11) == 0, a,
           {32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B)}, i[4], i[6:5], "R11");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule